// File: doc/BRIEF.md
# SRAM Two-Phase Strobe Generator

This block produces the internal timing strobes of a synchronous single-port SRAM macro. It takes an external clock, a chip select and a write enable. It buffers the clock and inverts it, then gates both phases with a registered chip select. From these it derives four strobes: a word line enable, an active-low precharge control, a write driver enable and a sense amplifier enable. Each clock cycle has two halves. The high half is used for input capture, precharge and address decode, and the low half is used for the array access itself.

The sense amplifier enable does not come from a clock edge. A replica read path produces it: the word line pulse of a read cycle enters a model of a replica column and its delay line. That model is a shift register of `DELAY_STAGES` stages, clocked by a separate fast sampling clock. The register is cleared asynchronously as soon as the low half of the cycle ends, so the sense enable can never reach into the next precharge half. Writes never start the replica path.

Top module: `sram_strobe_gen`

## Requirements
- R1: While `rstN` is low, `wlEn`, `wrEn`, `senseEn`, `gatedClkHi` and `gatedClkLo` are 0 and `pchgCtlN` is 1. They stay in that state after reset is released until a cycle whose captured `csIn` is 1.
- R2: `csIn` and `weIn` take effect only at a rising edge of `bufClk`. A change between two edges leaves every strobe unchanged until the next rising edge.
- R3: `bufClk` follows `clkIn`, and `invClk` is its inverse.
- R4: `gatedClkHi` is 1 exactly during the high half of a cycle whose captured chip select is 1. `gatedClkLo` is 1 exactly during the low half of such a cycle. Both are 0 for the whole of a deselected cycle.
- R5: `wlEn` is 1 only during the low half of a selected cycle, for reads and writes alike.
- R6: `pchgCtlN` is the inverse of `gatedClkLo`. It is 1 throughout every high half and every deselected cycle, and 0 during the low half of a selected read or write.
- R7: `wrEn` equals the `weIn` value captured at the last rising edge, for the whole cycle, whatever the chip select.
- R8: In a selected cycle with captured write enable 0, `senseEn` rises at the `DELAY_STAGES`-th rising edge of `sampleClk` after the low half begins. It stays 0 in write cycles and in deselected cycles.
- R9: `senseEn` falls at the rising edge of `bufClk` that ends the low half, with no `sampleClk` edge needed. It is only ever 1 while `wlEn` is 1.
- R10: Pulling `rstN` low during the low half of a selected cycle drops `wlEn`, `wrEn`, `gatedClkLo` and `senseEn` and raises `pchgCtlN` at once, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkIn | input | 1 | External clock |
| sampleClk | input | 1 | Fast sampling clock for the replica delay model |
| rstN | input | 1 | Asynchronous reset, active low |
| csIn | input | 1 | Chip select, captured on the rising edge |
| weIn | input | 1 | Write enable (1 = write), captured on the rising edge |
| bufClk | output | 1 | Buffered clock that drives every flip-flop |
| invClk | output | 1 | Inverse of the buffered clock |
| gatedClkHi | output | 1 | Buffered clock gated by the registered chip select |
| gatedClkLo | output | 1 | Inverted clock gated by the registered chip select |
| wlEn | output | 1 | Word line enable |
| pchgCtlN | output | 1 | Precharge control, active low |
| wrEn | output | 1 | Write driver enable |
| senseEn | output | 1 | Sense amplifier enable from the replica path |

## Verification
Chip select and write enable pass through one register, so the bench drives them late in the low half and looks for their effect only after the next rising edge. The high-half strobes and `wrEn` are sampled 1 ns after that edge. The low-half strobes are sampled 2 ns into the low half, which comes before the replica delay can expire with four stages of a 2 ns sampling clock, so `senseEn` is still expected at 0 there. They are sampled again 8 ns into the low half, after the fourth sampling edge, where `senseEn` is expected at 1 on reads. Checks at 1 ns after the rising edge confirm that `senseEn` has already fallen, and checks 1 ns after a mid-cycle reset confirm the asynchronous drop.

// File: rtl/sram_strobe_pkg.sv
`timescale 1ns/1ps
package sram_strobe_pkg;

  // Strobe bundle passed from the control half to the datapath half
  typedef struct packed {
    logic csReg;     // chip select captured on the rising edge
    logic weReg;     // write enable captured on the rising edge
    logic gatedHi;   // selected high phase
    logic gatedLo;   // selected low phase
  } strobe_t;

endpackage

// File: rtl/sram_strobe_ctl.sv
`timescale 1ns/1ps
module sram_strobe_ctl
  import sram_strobe_pkg::*;
(
  input  logic    clkIn,
  input  logic    rstN,
  input  logic    csIn,
  input  logic    weIn,
  output logic    bufClk,
  output logic    invClk,
  output strobe_t strobe
);

  logic csReg;
  logic weReg;

  // Clock tree: one buffer drives every flop, the inverse feeds the low-phase gating
  assign bufClk = clkIn;
  assign invClk = ~bufClk;

  // Control capture on the rising edge
  always_ff @(posedge bufClk or negedge rstN) begin
    if (!rstN) begin
      csReg <= 1'b0;
      weReg <= 1'b0;
    end else begin
      csReg <= csIn;
      weReg <= weIn;
    end
  end

  // Gated phases; csReg only changes while invClk is low, so gatedLo is glitch free
  always_comb begin
    strobe.csReg   = csReg;
    strobe.weReg   = weReg;
    strobe.gatedHi = csReg & bufClk;
    strobe.gatedLo = csReg & invClk;
  end

  // R4
  desel_gate_chk: assert property (@(posedge bufClk) disable iff (!rstN)
    !csIn |=> !strobe.gatedLo);

endmodule

// File: rtl/sram_strobe_dp.sv
`timescale 1ns/1ps
module sram_strobe_dp
  import sram_strobe_pkg::*;
#(
  parameter int DELAY_STAGES = 4
) (
  input  logic    sampleClk,
  input  logic    rstN,
  input  strobe_t strobe,
  output logic    gatedClkHi,
  output logic    gatedClkLo,
  output logic    wlEn,
  output logic    pchgCtlN,
  output logic    wrEn,
  output logic    senseEn
);

  localparam int CNT_W = $clog2(DELAY_STAGES + 1);

  logic                    rblWl;
  logic                    clrN;
  logic [DELAY_STAGES-1:0] tap;

  // Array-facing strobes
  assign gatedClkHi = strobe.gatedHi;
  assign gatedClkLo = strobe.gatedLo;
  assign wlEn       = strobe.gatedLo;
  assign pchgCtlN   = ~strobe.gatedLo;
  assign wrEn       = strobe.weReg;

  // Replica word line fires only in the low phase of a read
  assign rblWl = strobe.gatedLo & ~strobe.weReg;
  assign clrN  = rstN & rblWl;

  // Replica column plus delay line as a shift chain, cleared when the pulse ends
  for (genvar g = 0; g < DELAY_STAGES; g++) begin : gStage
    if (g == 0) begin : gHead
      always_ff @(posedge sampleClk or negedge clrN) begin
        if (!clrN) tap[g] <= 1'b0;
        else       tap[g] <= rblWl;
      end
    end else begin : gBody
      always_ff @(posedge sampleClk or negedge clrN) begin
        if (!clrN) tap[g] <= 1'b0;
        else       tap[g] <= tap[g-1];
      end
    end
  end

  // Output buffer, qualified so it drops with the phase
  assign senseEn = tap[DELAY_STAGES-1] & rblWl;

  // Independent count of sampling edges seen in the current read pulse
  logic [CNT_W-1:0] pulseCnt;
  always_ff @(posedge sampleClk or negedge clrN) begin
    if (!clrN)                        pulseCnt <= '0;
    else if (pulseCnt != DELAY_STAGES[CNT_W-1:0]) pulseCnt <= pulseCnt + 1'b1;
  end

  // R8
  sense_delay_chk: assert property (@(posedge sampleClk) disable iff (!rstN)
    senseEn |-> (pulseCnt == DELAY_STAGES[CNT_W-1:0]));

  // R8
  sense_no_write_chk: assert property (@(posedge sampleClk) disable iff (!rstN)
    senseEn |-> !wrEn);

  // R9
  sense_in_wl_chk: assert property (@(posedge sampleClk) disable iff (!rstN)
    senseEn |-> strobe.csReg);

endmodule

// File: rtl/sram_strobe_gen.sv
`timescale 1ns/1ps
module sram_strobe_gen
  import sram_strobe_pkg::*;
#(
  parameter int DELAY_STAGES = 4
) (
  input  logic clkIn,
  input  logic sampleClk,
  input  logic rstN,
  input  logic csIn,
  input  logic weIn,
  output logic bufClk,
  output logic invClk,
  output logic gatedClkHi,
  output logic gatedClkLo,
  output logic wlEn,
  output logic pchgCtlN,
  output logic wrEn,
  output logic senseEn
);

  strobe_t strobe;

  sram_strobe_ctl uCtl (
    .clkIn  (clkIn),
    .rstN   (rstN),
    .csIn   (csIn),
    .weIn   (weIn),
    .bufClk (bufClk),
    .invClk (invClk),
    .strobe (strobe)
  );

  sram_strobe_dp #(.DELAY_STAGES(DELAY_STAGES)) uDp (
    .sampleClk  (sampleClk),
    .rstN       (rstN),
    .strobe     (strobe),
    .gatedClkHi (gatedClkHi),
    .gatedClkLo (gatedClkLo),
    .wlEn       (wlEn),
    .pchgCtlN   (pchgCtlN),
    .wrEn       (wrEn),
    .senseEn    (senseEn)
  );

endmodule

// File: tb/sram_strobe_gen_test.sv
`timescale 1ns/1ps
module sram_strobe_gen_test;

  logic clkIn = 1'b0;
  logic sampleClk = 1'b0;
  logic rstN, csIn, weIn;
  logic bufClk, invClk, gatedClkHi, gatedClkLo, wlEn, pchgCtlN, wrEn, senseEn;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // {cs, we}
  localparam logic [1:0] VECS [0:9] = '{2'b10, 2'b11, 2'b00, 2'b01, 2'b10,
                                        2'b10, 2'b11, 2'b00, 2'b10, 2'b01};

  sram_strobe_gen #(.DELAY_STAGES(4)) uut (
    .clkIn(clkIn), .sampleClk(sampleClk), .rstN(rstN), .csIn(csIn), .weIn(weIn),
    .bufClk(bufClk), .invClk(invClk), .gatedClkHi(gatedClkHi), .gatedClkLo(gatedClkLo),
    .wlEn(wlEn), .pchgCtlN(pchgCtlN), .wrEn(wrEn), .senseEn(senseEn)
  );

  always #10 clkIn = ~clkIn;           // 50 MHz, rising edges at 10, 30, ...

  initial begin                        // 2 ns sampling clock, rising on odd ns
    #1;
    forever begin
      sampleClk = 1'b1; #1;
      sampleClk = 1'b0; #1;
    end
  end

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Drives inputs now (late low phase), then checks the following cycle; returns at P+19
  task automatic runCycle(input logic cs, input logic we);
    csIn = cs; weIn = we;
    @(posedge clkIn);
    #1;
    chk("R3", "bufClk", bufClk, 1'b1);
    chk("R3", "invClk", invClk, 1'b0);
    chk("R4", "gatedClkHi", gatedClkHi, cs);
    chk("R4", "gatedClkLo high", gatedClkLo, 1'b0);
    chk("R5", "wlEn high", wlEn, 1'b0);
    chk("R6", "pchgCtlN high", pchgCtlN, 1'b1);
    chk("R7", "wrEn", wrEn, we);
    chk("R9", "senseEn after edge", senseEn, 1'b0);
    #11;
    chk("R3", "invClk low", invClk, 1'b1);
    chk("R4", "gatedClkHi low", gatedClkHi, 1'b0);
    chk("R4", "gatedClkLo low", gatedClkLo, cs);
    chk("R5", "wlEn low", wlEn, cs);
    chk("R6", "pchgCtlN low", pchgCtlN, ~cs);
    chk("R8", "senseEn early", senseEn, 1'b0);
    #6;
    chk("R8", "senseEn late", senseEn, cs & ~we);
    chk("R7", "wrEn late", wrEn, we);
    #1;
  endtask

  initial begin
    rstN = 1'b0; csIn = 1'b1; weIn = 1'b1;
    #1;
    chk("R1", "wlEn in reset", wlEn, 1'b0);
    chk("R1", "pchgCtlN in reset", pchgCtlN, 1'b1);
    @(posedge clkIn);
    #12;
    chk("R1", "wlEn in reset low", wlEn, 1'b0);
    chk("R1", "wrEn in reset", wrEn, 1'b0);
    chk("R1", "senseEn in reset", senseEn, 1'b0);
    chk("R1", "gatedClkLo in reset", gatedClkLo, 1'b0);
    #7;
    rstN = 1'b1;
    runCycle(1'b0, 1'b0);               // R1: still idle until a selected cycle

    foreach (VECS[i]) runCycle(VECS[i][1], VECS[i][0]);

    // R2: inputs changed mid-cycle have no effect before the next edge
    csIn = 1'b0; weIn = 1'b0;
    @(posedge clkIn);
    #12;
    csIn = 1'b1; weIn = 1'b1;
    #3;
    chk("R2", "wlEn after mid-cycle cs", wlEn, 1'b0);
    chk("R2", "wrEn after mid-cycle we", wrEn, 1'b0);
    chk("R2", "pchgCtlN after mid-cycle cs", pchgCtlN, 1'b1);
    #4;
    runCycle(1'b1, 1'b0);

    // R10: reset in the middle of a read access
    csIn = 1'b1; weIn = 1'b0;
    @(posedge clkIn);
    #14;
    chk("R10", "wlEn before reset", wlEn, 1'b1);
    rstN = 1'b0;
    #1;
    chk("R10", "wlEn after reset", wlEn, 1'b0);
    chk("R10", "senseEn after reset", senseEn, 1'b0);
    chk("R10", "gatedClkLo after reset", gatedClkLo, 1'b0);
    chk("R10", "pchgCtlN after reset", pchgCtlN, 1'b1);
    #4;
    rstN = 1'b1;
    runCycle(1'b1, 1'b1);
    runCycle(1'b1, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule